// File: doc/BRIEF.md
# Directory Miss Reply Controller

This block sits at the directory of a coherent multi-node system whose links carry encrypted traffic. It takes one cache-miss request at a time. At acceptance it samples a lookup port that gives the block's coherence state, its match status bit, its owner and its per-block counter. One cycle later it sends a short reply to the requestor. The reply names the node that will supply the data and carries the match bit. It holds no counter value, because the requestor can predict the counter on its own.

What happens next depends on the lookup. A set match bit ends the transaction at the reply. When another node owns the block, the request is forwarded to that owner. When the directory itself supplies the data, three things start in the same cycle: the memory fetch, a pad generation keyed by the block's own counter, and a pad generation keyed by the global counter that belongs to this directory-requestor pair. Once the fetch and both pads are in, the data is decrypted with the block pad and passed through an external compressor. The result is encrypted with the pair pad and sent as a data message. That pair's counter then advances.

Memory, both pad generators and the compressor are reached through request pulses and valid responses. The cipher and the compression themselves are outside this block.

Top module: `dmr_dir_miss_ctrl`

## Requirements
- R1: A request is accepted when `req_valid` and `req_ready` are both high. Exactly one cycle later `reply_valid` pulses for one cycle, with `reply_dst` equal to the requestor and `reply_match` equal to the sampled `lk_match`.
- R2: Coherence states are encoded on `lk_state` as 0 = invalid, 1 = shared, 2 = owned, 3 = modified. For states 0 and 1, `reply_supplier` equals the parameter `DIR_ID`.
- R3: For states 2 and 3, `reply_supplier` equals `lk_owner`. If the match bit is clear, `fwd_valid` pulses in the reply cycle with `fwd_dst` = owner, `fwd_req` = requestor and `fwd_addr` = the request address, and no memory fetch is started.
- R4: With the match bit set, the reply cycle shows no memory request, no forward and no data message, and `req_ready` is high again in the following cycle.
- R5: For states 0 and 1 with the match bit clear, `mem_req_valid`, `blk_pad_req` and `pair_pad_req` pulse together in the reply cycle. `blk_pad_ctr` equals the sampled `lk_blk_ctr`, `blk_pad_addr` equals the address, `pair_pad_peer` equals the requestor, and `pair_pad_ctr` equals the requestor's current pair counter.
- R6: The compressor is given `cmp_in` = memory data XOR block pad. The data message carries `data_payload` = `cmp_out` XOR pair pad and `data_dst` = requestor. `cmp_req_valid` rises in the cycle right after the last of the memory data and the two pads arrives.
- R7: Every pair counter starts at zero after reset. The requestor's counter increases by one, modulo 2^CTR_W, after each data message sent to it. Counters of other requestors do not change.
- R8: Only one miss is in flight at a time. `req_ready` is low from the cycle after acceptance until the transaction ends. A request held during that time receives no reply.
- R9: If the memory data arrives before both pads, the controller waits. It issues no compressor request until both pad-valid inputs have been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Controller idle, can accept |
| req_src | input | NODE_W | Requesting node |
| req_addr | input | ADDR_W | Block address |
| lk_addr | output | ADDR_W | Address presented to the directory lookup |
| lk_state | input | 2 | Coherence state of the block |
| lk_match | input | 1 | Match status bit of the block |
| lk_owner | input | NODE_W | Owner node for owned or modified blocks |
| lk_blk_ctr | input | CTR_W | Per-block counter of the memory copy |
| reply_valid | output | 1 | Reply pulse |
| reply_dst | output | NODE_W | Reply destination (requestor) |
| reply_supplier | output | NODE_W | Node that supplies the data |
| reply_match | output | 1 | Match bit carried in the reply |
| fwd_valid | output | 1 | Forward pulse to the owner |
| fwd_dst | output | NODE_W | Owner node |
| fwd_req | output | NODE_W | Original requestor |
| fwd_addr | output | ADDR_W | Block address |
| mem_req_valid | output | 1 | Memory read pulse |
| mem_req_addr | output | ADDR_W | Memory read address |
| mem_rsp_valid | input | 1 | Memory data valid |
| mem_rsp_data | input | DATA_W | Encrypted memory data |
| blk_pad_req | output | 1 | Block pad generation pulse |
| blk_pad_ctr | output | CTR_W | Per-block counter for the pad |
| blk_pad_addr | output | ADDR_W | Address for the block pad |
| blk_pad_valid | input | 1 | Block pad ready |
| blk_pad | input | DATA_W | Block pad |
| pair_pad_req | output | 1 | Pair pad generation pulse |
| pair_pad_ctr | output | CTR_W | Pair counter of the current requestor |
| pair_pad_peer | output | NODE_W | Peer node for the pair pad |
| pair_pad_valid | input | 1 | Pair pad ready |
| pair_pad | input | DATA_W | Pair pad |
| cmp_req_valid | output | 1 | Compressor request pulse |
| cmp_in | output | DATA_W | Decrypted block to compress |
| cmp_rsp_valid | input | 1 | Compressor result valid |
| cmp_out | input | DATA_W | Compressed block |
| data_valid | output | 1 | Data message pulse |
| data_dst | output | NODE_W | Data destination |
| data_payload | output | DATA_W | Encrypted compressed data |

## Verification
The wait for pads after the memory data is in is the hardest case to reach from the ports. It needs memory to answer before one or both pad generators. The bench models memory, the pads and the compressor as independent responders with a delay set per transaction. Directed cases force memory-first, pads-first and same-cycle arrival, and the random phase draws all three delays freely. Counter wrap-around is reached with a narrow counter and a run of data messages to one requestor.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
   typedef enum logic [1:0] {
      COH_I = 2'd0,
      COH_S = 2'd1,
      COH_O = 2'd2,
      COH_M = 2'd3
   } coh_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REPLY,
      ST_FETCH,
      ST_PADW,
      ST_CMP,
      ST_CWAIT,
      ST_SEND
   } ctl_e;
endpackage

// File: rtl/dmr_pad_hold.sv
module dmr_pad_hold #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         ld,
   input  logic [W-1:0] din,
   output logic         rdy,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy <= 1'b0;
         q   <= '0;
      end else if (clr) begin
         rdy <= 1'b0;
      end else if (ld) begin
         rdy <= 1'b1;
         q   <= din;
      end
   end
endmodule

// File: rtl/dmr_pair_ctr_bank.sv
module dmr_pair_ctr_bank #(
   parameter int NODES  = 8,
   parameter int NODE_W = 3,
   parameter int CTR_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic [NODE_W-1:0] sel,
   output logic [CTR_W-1:0]  cnt_sel
);
   localparam logic [CTR_W-1:0] STEP = CTR_W'(1);

   logic [CTR_W-1:0] cnt [NODES];

   for (genvar i = 0; i < NODES; i++) begin : g_ctr
      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt[i] <= '0;
         else if (inc && (sel == NODE_W'(i)))
            cnt[i] <= cnt[i] + STEP;
      end
   end

   always_comb begin
      cnt_sel = '0;
      for (int k = 0; k < NODES; k++)
         if (sel == NODE_W'(k)) cnt_sel = cnt[k];
   end

   AST_PAIR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      inc |=> cnt_sel == $past(cnt_sel) + STEP); // R7
endmodule

// File: rtl/dmr_dir_miss_ctrl.sv
module dmr_dir_miss_ctrl
   import dmr_pkg::*;
#(
   parameter int NODES  = 8,
   parameter int NODE_W = 3,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int CTR_W  = 16,
   parameter int DIR_ID = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [NODE_W-1:0] req_src,
   input  logic [ADDR_W-1:0] req_addr,
   output logic [ADDR_W-1:0] lk_addr,
   input  logic [1:0]        lk_state,
   input  logic              lk_match,
   input  logic [NODE_W-1:0] lk_owner,
   input  logic [CTR_W-1:0]  lk_blk_ctr,
   output logic              reply_valid,
   output logic [NODE_W-1:0] reply_dst,
   output logic [NODE_W-1:0] reply_supplier,
   output logic              reply_match,
   output logic              fwd_valid,
   output logic [NODE_W-1:0] fwd_dst,
   output logic [NODE_W-1:0] fwd_req,
   output logic [ADDR_W-1:0] fwd_addr,
   output logic              mem_req_valid,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   output logic              blk_pad_req,
   output logic [CTR_W-1:0]  blk_pad_ctr,
   output logic [ADDR_W-1:0] blk_pad_addr,
   input  logic              blk_pad_valid,
   input  logic [DATA_W-1:0] blk_pad,
   output logic              pair_pad_req,
   output logic [CTR_W-1:0]  pair_pad_ctr,
   output logic [NODE_W-1:0] pair_pad_peer,
   input  logic              pair_pad_valid,
   input  logic [DATA_W-1:0] pair_pad,
   output logic              cmp_req_valid,
   output logic [DATA_W-1:0] cmp_in,
   input  logic              cmp_rsp_valid,
   input  logic [DATA_W-1:0] cmp_out,
   output logic              data_valid,
   output logic [NODE_W-1:0] data_dst,
   output logic [DATA_W-1:0] data_payload
);
   localparam logic [NODE_W-1:0] SELF = NODE_W'(DIR_ID);

   if (NODES < 2 || NODES > (1 << NODE_W) || DIR_ID >= NODES ||
       ADDR_W < 1 || DATA_W < 1 || CTR_W < 1) begin : g_bad_cfg
      initial $fatal(1, "dmr_dir_miss_ctrl: inconsistent parameters");
   end

   ctl_e              st;
   logic [NODE_W-1:0] src_q, sup_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CTR_W-1:0]  bctr_q;
   logic [DATA_W-1:0] mem_q, out_q;
   logic              match_q, own_q;
   logic              acc, own_in, blk_rdy, pair_rdy, blk_ok, pair_ok, busy;
   logic [DATA_W-1:0] blk_q, pair_q;

   assign acc     = req_valid && req_ready;
   assign own_in  = (coh_e'(lk_state) == COH_O) || (coh_e'(lk_state) == COH_M);
   assign busy    = (st != ST_IDLE);
   assign blk_ok  = blk_rdy  || blk_pad_valid;
   assign pair_ok = pair_rdy || pair_pad_valid;

   dmr_pad_hold #(.W(DATA_W)) u_blk_hold (
      .clk(clk), .rst_n(rst_n), .clr(acc), .ld(blk_pad_valid && busy),
      .din(blk_pad), .rdy(blk_rdy), .q(blk_q));

   dmr_pad_hold #(.W(DATA_W)) u_pair_hold (
      .clk(clk), .rst_n(rst_n), .clr(acc), .ld(pair_pad_valid && busy),
      .din(pair_pad), .rdy(pair_rdy), .q(pair_q));

   dmr_pair_ctr_bank #(.NODES(NODES), .NODE_W(NODE_W), .CTR_W(CTR_W)) u_ctrs (
      .clk(clk), .rst_n(rst_n), .inc(st == ST_SEND), .sel(src_q),
      .cnt_sel(pair_pad_ctr));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         src_q   <= '0;
         sup_q   <= '0;
         addr_q  <= '0;
         bctr_q  <= '0;
         mem_q   <= '0;
         out_q   <= '0;
         match_q <= 1'b0;
         own_q   <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: if (acc) begin
               src_q   <= req_src;
               addr_q  <= req_addr;
               match_q <= lk_match;
               own_q   <= own_in;
               sup_q   <= own_in ? lk_owner : SELF;
               bctr_q  <= lk_blk_ctr;
               st      <= ST_REPLY;
            end
            ST_REPLY: st <= (match_q || own_q) ? ST_IDLE : ST_FETCH;
            ST_FETCH: if (mem_rsp_valid) begin
               mem_q <= mem_rsp_data;
               st    <= (blk_ok && pair_ok) ? ST_CMP : ST_PADW;
            end
            ST_PADW: if (blk_ok && pair_ok) st <= ST_CMP;
            ST_CMP:  st <= ST_CWAIT;
            ST_CWAIT: if (cmp_rsp_valid) begin
               out_q <= cmp_out ^ pair_q;
               st    <= ST_SEND;
            end
            ST_SEND: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req_ready      = (st == ST_IDLE);
   assign lk_addr        = req_addr;
   assign reply_valid    = (st == ST_REPLY);
   assign reply_dst      = src_q;
   assign reply_supplier = sup_q;
   assign reply_match    = match_q;
   assign fwd_valid      = reply_valid && own_q && !match_q;
   assign fwd_dst        = sup_q;
   assign fwd_req        = src_q;
   assign fwd_addr       = addr_q;
   assign mem_req_valid  = reply_valid && !own_q && !match_q;
   assign mem_req_addr   = addr_q;
   assign blk_pad_req    = mem_req_valid;
   assign blk_pad_ctr    = bctr_q;
   assign blk_pad_addr   = addr_q;
   assign pair_pad_req   = mem_req_valid;
   assign pair_pad_peer  = src_q;
   assign cmp_req_valid  = (st == ST_CMP);
   assign cmp_in         = mem_q ^ blk_q;
   assign data_valid     = (st == ST_SEND);
   assign data_dst       = src_q;
   assign data_payload   = out_q;

   AST_REPLY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> reply_valid && reply_match == $past(lk_match)); // R1
   AST_DIR_SUPPLIES: assert property (@(posedge clk) disable iff (!rst_n)
      acc && (lk_state == COH_I || lk_state == COH_S) |=> reply_supplier == SELF); // R2
   AST_FWD_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      acc && (lk_state == COH_O || lk_state == COH_M) && !lk_match
      |=> fwd_valid && fwd_dst == $past(lk_owner) && !mem_req_valid); // R3
   AST_MATCH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      reply_valid && reply_match |=> req_ready); // R4
   AST_FETCH_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      acc && (lk_state == COH_I || lk_state == COH_S) && !lk_match
      |=> mem_req_valid && blk_pad_ctr == $past(lk_blk_ctr)); // R5
   AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> !req_ready); // R8
   AST_CMP_PADS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_req_valid |-> blk_rdy && pair_rdy); // R9
endmodule

// File: tb/dmr_dir_miss_ctrl_tb.sv
module dmr_dir_miss_ctrl_tb;
   localparam int NODES = 8, NODE_W = 3, ADDR_W = 16, DATA_W = 32, CTR_W = 4, DIR_ID = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic              req_valid = 1'b0, req_ready;
   logic [NODE_W-1:0] req_src = '0;
   logic [ADDR_W-1:0] req_addr = '0, lk_addr;
   logic [1:0]        lk_state = '0;
   logic              lk_match = 1'b0;
   logic [NODE_W-1:0] lk_owner = '0;
   logic [CTR_W-1:0]  lk_blk_ctr = '0;
   logic              reply_valid, reply_match, fwd_valid, mem_req_valid;
   logic [NODE_W-1:0] reply_dst, reply_supplier, fwd_dst, fwd_req, pair_pad_peer, data_dst;
   logic [ADDR_W-1:0] fwd_addr, mem_req_addr, blk_pad_addr;
   logic              mem_rsp_valid = 1'b0, blk_pad_valid = 1'b0, pair_pad_valid = 1'b0, cmp_rsp_valid = 1'b0;
   logic [DATA_W-1:0] mem_rsp_data = '0, blk_pad = '0, pair_pad = '0, cmp_out = '0;
   logic              blk_pad_req, pair_pad_req, cmp_req_valid, data_valid;
   logic [CTR_W-1:0]  blk_pad_ctr, pair_pad_ctr;
   logic [DATA_W-1:0] cmp_in, data_payload;

   dmr_dir_miss_ctrl #(.NODES(NODES), .NODE_W(NODE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                       .CTR_W(CTR_W), .DIR_ID(DIR_ID)) u_dut (.*);

   int tests = 0, fails = 0, cyc = 0;
   int d_mem = 1, d_blk = 1, d_pair = 1, d_cmp = 1;
   int c_mem = 0, c_blk = 0, c_pair = 0;
   bit done_blk = 0, done_pair = 0;
   logic [ADDR_W-1:0] cur_addr = '0;
   logic [CTR_W-1:0]  cur_bctr = '0;
   logic [CTR_W-1:0]  exp_ctr [NODES];

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [DATA_W-1:0] f_mem(logic [ADDR_W-1:0] a);
      return {a, ~a} ^ 32'hDEADBEEF;
   endfunction
   function automatic logic [DATA_W-1:0] f_pblk(logic [CTR_W-1:0] c, logic [ADDR_W-1:0] a);
      return ({c, 12'h0, a} * 32'h9E3779B1) ^ 32'h5A5A0F0F;
   endfunction
   function automatic logic [DATA_W-1:0] f_ppair(logic [CTR_W-1:0] c, logic [NODE_W-1:0] n);
      return ({c, 25'h0, n} * 32'h85EBCA6B) ^ 32'h0F0F3C3C;
   endfunction
   function automatic logic [DATA_W-1:0] f_cmp(logic [DATA_W-1:0] x);
      return {x[26:0], x[31:27]} ^ 32'h12345678;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // memory responder
   initial forever begin
      @(negedge clk);
      if (mem_req_valid) begin
         automatic logic [ADDR_W-1:0] a = mem_req_addr;
         repeat (d_mem) @(negedge clk);
         mem_rsp_valid = 1'b1; mem_rsp_data = f_mem(a); c_mem = cyc;
         @(negedge clk); mem_rsp_valid = 1'b0;
      end
   end
   // block pad responder
   initial forever begin
      @(negedge clk);
      if (blk_pad_req) begin
         automatic logic [ADDR_W-1:0] a = blk_pad_addr;
         automatic logic [CTR_W-1:0]  c = blk_pad_ctr;
         repeat (d_blk) @(negedge clk);
         blk_pad_valid = 1'b1; blk_pad = f_pblk(c, a); c_blk = cyc; done_blk = 1;
         @(negedge clk); blk_pad_valid = 1'b0;
      end
   end
   // pair pad responder
   initial forever begin
      @(negedge clk);
      if (pair_pad_req) begin
         automatic logic [NODE_W-1:0] n = pair_pad_peer;
         automatic logic [CTR_W-1:0]  c = pair_pad_ctr;
         repeat (d_pair) @(negedge clk);
         pair_pad_valid = 1'b1; pair_pad = f_ppair(c, n); c_pair = cyc; done_pair = 1;
         @(negedge clk); pair_pad_valid = 1'b0;
      end
   end
   // compressor responder
   initial forever begin
      @(negedge clk);
      if (cmp_req_valid) begin
         automatic logic [DATA_W-1:0] x = cmp_in;
         automatic int last = c_mem;
         if (c_blk > last) last = c_blk;
         if (c_pair > last) last = c_pair;
         chk(done_blk && done_pair, "R9", "pads seen before compress", {done_blk, done_pair}, 2'b11);
         chk(cyc == last + 1, "R6", "compress start cycle", cyc, last + 1);
         chk(x == (f_mem(cur_addr) ^ f_pblk(cur_bctr, cur_addr)), "R6", "cmp_in",
             x, f_mem(cur_addr) ^ f_pblk(cur_bctr, cur_addr));
         repeat (d_cmp) @(negedge clk);
         cmp_rsp_valid = 1'b1; cmp_out = f_cmp(x);
         @(negedge clk); cmp_rsp_valid = 1'b0;
      end
   end

   task automatic run_miss(input int src, input int addr, input int st, input bit m,
                           input int owner, input int bctr);
      automatic bit own = (st >= 2);
      automatic bit exp_data = !own && !m;
      automatic logic [NODE_W-1:0] exp_sup = own ? NODE_W'(owner) : NODE_W'(DIR_ID);
      automatic int n = 0;
      automatic bit busy_ok = 1;
      automatic logic [NODE_W-1:0] s = NODE_W'(src);
      @(negedge clk);
      while (!req_ready && n < 200) begin @(negedge clk); n++; end
      done_blk = 0; done_pair = 0;
      cur_addr = ADDR_W'(addr); cur_bctr = CTR_W'(bctr);
      req_valid = 1'b1; req_src = s; req_addr = ADDR_W'(addr);
      lk_state = 2'(st); lk_match = m; lk_owner = NODE_W'(owner); lk_blk_ctr = CTR_W'(bctr);
      @(negedge clk);
      req_valid = 1'b0;
      chk(reply_valid && reply_dst == s && reply_match == m, "R1", "reply",
          {reply_valid, reply_dst, reply_match}, {1'b1, s, m});
      chk(reply_supplier == exp_sup, own ? "R3" : "R2", "supplier", reply_supplier, exp_sup);
      chk(fwd_valid == (own && !m), "R3", "fwd_valid", fwd_valid, own && !m);
      if (own && !m)
         chk(fwd_dst == NODE_W'(owner) && fwd_req == s && fwd_addr == ADDR_W'(addr), "R3",
             "fwd fields", {fwd_dst, fwd_req, fwd_addr}, {NODE_W'(owner), s, ADDR_W'(addr)});
      chk(mem_req_valid == exp_data && blk_pad_req == exp_data && pair_pad_req == exp_data,
          m ? "R4" : "R5", "launch pulses", {mem_req_valid, blk_pad_req, pair_pad_req},
          {3{exp_data}});
      if (!exp_data) begin
         @(negedge clk);
         chk(req_ready && !data_valid, own && !m ? "R3" : "R4", "back to idle, no data",
             {req_ready, data_valid}, 2'b10);
      end else begin
         chk(blk_pad_ctr == CTR_W'(bctr) && blk_pad_addr == ADDR_W'(addr) && mem_req_addr == ADDR_W'(addr),
             "R5", "block pad ctr/addr", {blk_pad_ctr, blk_pad_addr}, {CTR_W'(bctr), ADDR_W'(addr)});
         chk(pair_pad_ctr == exp_ctr[src] && pair_pad_peer == s, "R7", "pair counter",
             pair_pad_ctr, exp_ctr[src]);
         req_valid = 1'b1; req_src = NODE_W'(src + 1); req_addr = ADDR_W'(addr ^ 16'h5555);
         n = 0;
         forever begin
            @(negedge clk);
            if (data_valid || n > 200) break;
            if (reply_valid || req_ready) busy_ok = 0;
            n++;
         end
         req_valid = 1'b0;
         chk(busy_ok, "R8", "busy: no ready, no reply", busy_ok, 1);
         begin
            automatic logic [DATA_W-1:0] e =
               f_cmp(f_mem(ADDR_W'(addr)) ^ f_pblk(CTR_W'(bctr), ADDR_W'(addr))) ^ f_ppair(exp_ctr[src], s);
            chk(data_valid && data_payload == e && data_dst == s, "R6", "data message",
                data_payload, e);
         end
         exp_ctr[src] = exp_ctr[src] + 1'b1;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < NODES; i++) exp_ctr[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !reply_valid && !fwd_valid && !mem_req_valid && !data_valid && !cmp_req_valid,
          "R8", "reset state", {req_ready, reply_valid, data_valid}, 3'b100);
      chk(pair_pad_ctr == '0, "R7", "counter after reset", pair_pad_ctr, 0);
      // memory first, pads late: pad wait
      d_mem = 1; d_blk = 5; d_pair = 3; d_cmp = 2;
      run_miss(1, 16'h1234, 0, 0, 0, 3);
      run_miss(2, 16'h0042, 1, 1, 0, 7);          // shared, match set
      run_miss(4, 16'hBEEF, 3, 0, 2, 1);          // modified, forwarded
      run_miss(5, 16'h7777, 2, 1, 4, 9);          // owned, match set
      d_mem = 2; d_blk = 2; d_pair = 2; d_cmp = 1;
      run_miss(1, 16'hA0A0, 1, 0, 0, 15);         // all arrive same cycle
      d_mem = 6; d_blk = 1; d_pair = 2; d_cmp = 4;
      run_miss(0, 16'h0001, 0, 0, 3, 0);          // pads before memory
      d_mem = 1; d_blk = 1; d_pair = 1; d_cmp = 1;
      for (int i = 0; i < 17; i++) run_miss(3, i * 97, 0, 0, 0, i);   // R7 wrap
      for (int i = 0; i < 60; i++) begin
         d_mem = 1 + int'($urandom % 6); d_blk = 1 + int'($urandom % 6);
         d_pair = 1 + int'($urandom % 6); d_cmp = 1 + int'($urandom % 4);
         run_miss(int'($urandom % NODES), int'($urandom % 65536), int'($urandom % 4),
                  ($urandom % 4) == 0, int'($urandom % NODES), int'($urandom % 16));
      end
      repeat (3) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule